// File: doc/BRIEF.md
# Multi-Bank In-Order Response Sequencer

This block connects one host request port to a set of independent memory banks. Each accepted request goes to a single bank, chosen by a field of the request address. Banks can take very different times to answer, so a request issued later to one bank may finish before an earlier request issued to another bank. The block returns every response to the host strictly in the order the requests were accepted.

An order FIFO records the bank index of each accepted request, and its head names the bank whose response is due next. Each bank has a small holding buffer. A response that arrives before its turn waits in that buffer. A response that arrives when it is due and finds the buffer empty goes straight to the host in the same cycle.

A bank stays closed to new requests while it has a request in flight or a held response that the host has not yet taken. The request side is valid/ready. A request is accepted on a rising clock edge where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` may depend on the presented address, because it reflects the state of the selected bank. The response side has no back-pressure: the host takes each response in the cycle `rsp_done_o` is high.

Top module: `resp_sequencer`

## Requirements
- R1: `req_ready_o` is high only when all of the following hold: reset is released, the order FIFO has space, `bank_ready_i` of the selected bank is high, and that bank is free. The selected bank is `req_addr_i[BANK_LSB +: log2(NUM_BANKS)]`, and the default `BANK_LSB` is 0.
- R2: On an accepted request, exactly one bit of `bank_req_o` is high, the bit of the selected bank, and `bank_addr_o` equals `req_addr_i`. No bit of `bank_req_o` is high in any other cycle.
- R3: Responses reach the host in the order their requests were accepted, whatever the bank latencies.
- R4: `rsp_data_o` and `rsp_err_o` carry the data and error flag that the bank returned for the request being completed.
- R5: A response that arrives before its turn is held in its bank's buffer without loss until it is due.
- R6: A bank with a request in flight, or with a held response not yet delivered, gets no new request. While such a bank is selected, `req_ready_o` is low.
- R7: When the due bank's buffer is empty, a response from that bank appears on `rsp_done_o` in the same cycle as `bank_rsp_valid_i`.
- R8: The order FIFO holds `OUTSTANDING*NUM_BANKS` entries. When it is full, `req_ready_o` is low.
- R9: While `rst_ni` is low (synchronous), `req_ready_o` and `rsp_done_o` are low, and after reset all FIFOs are empty.
- R10: Each accepted request produces exactly one cycle of `rsp_done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Host request ready |
| req_addr_i | input | ADDR_W | Host request address |
| rsp_done_o | output | 1 | Response delivered this cycle |
| rsp_data_o | output | DATA_W | Response data |
| rsp_err_o | output | 1 | Response error flag |
| bank_req_o | output | NUM_BANKS | Per-bank request strobe |
| bank_addr_o | output | ADDR_W | Address sent to the banks |
| bank_ready_i | input | NUM_BANKS | Bank can take a request |
| bank_rsp_valid_i | input | NUM_BANKS | Bank response strobe |
| bank_rsp_data_i | input | NUM_BANKS*DATA_W | Bank response data, bank b at bits b*DATA_W |
| bank_rsp_err_i | input | NUM_BANKS | Bank response error flag |

## Verification
Two events can fall in the same cycle. One is the delivery of the head response, which pops the order FIFO. The other is the acceptance of a new request to a different bank, which pushes the order FIFO. Streaming bursts are sent while per-bank latencies are swept, so pushes and pops, as well as pass-through and held deliveries, overlap in many alignments. A scoreboard fed from accepted requests judges each delivered word and error flag against the expected request order. At the end it confirms that every accepted request was delivered exactly once.

// File: rtl/rspseq_pkg.sv
package rspseq_pkg;
  function automatic int idx_width(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/rspseq_order_fifo.sv
module rspseq_order_fifo
  import rspseq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int W     = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PW = idx_width(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_i) wr_ptr <= nxt(wr_ptr);
      if (pop_i)  rd_ptr <= nxt(rd_ptr);
      cnt <= cnt + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr] <= data_i;
  end

  assign head_o  = mem[rd_ptr];
  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CW'(DEPTH));

  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (cnt < CW'(DEPTH)));
  a_r3_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (cnt != '0));
endmodule

// File: rtl/rspseq_rsp_buf.sv
module rspseq_rsp_buf
  import rspseq_pkg::*;
#(
  parameter int DEPTH  = 1,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_err_i,
  input  logic              due_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_err_o,
  output logic              free_o
);
  localparam int PW = idx_width(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W:0] mem [DEPTH];
  logic [PW-1:0]   wr_ptr, rd_ptr;
  logic [CW-1:0]   cnt, inflight;
  logic            held, push, take;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign held        = (cnt != '0);
  assign out_valid_o = held | in_valid_i;
  assign out_data_o  = held ? mem[rd_ptr][DATA_W-1:0] : in_data_i;
  assign out_err_o   = held ? mem[rd_ptr][DATA_W]     : in_err_i;
  assign take        = due_i & out_valid_o;
  assign push        = in_valid_i & ~(~held & due_i);
  assign free_o      = ~held & (inflight < CW'(DEPTH));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      cnt      <= '0;
      inflight <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (take && held) rd_ptr <= nxt(rd_ptr);
      cnt      <= cnt + CW'(push) - CW'(take & held);
      inflight <= inflight + CW'(issue_i) - CW'(take);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push) mem[wr_ptr] <= {in_err_i, in_data_i};
  end

  a_r5_buf_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push |-> (cnt < CW'(DEPTH)));
  a_r6_issue_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> (!held && inflight < CW'(DEPTH)));
  a_r10_rsp_was_issued: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> (inflight > cnt));
endmodule

// File: rtl/resp_sequencer.sv
module resp_sequencer
  import rspseq_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 16,
  parameter int BANK_LSB    = 0,
  parameter int OUTSTANDING = 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_valid_i,
  output logic                        req_ready_o,
  input  logic [ADDR_W-1:0]           req_addr_i,
  output logic                        rsp_done_o,
  output logic [DATA_W-1:0]           rsp_data_o,
  output logic                        rsp_err_o,
  output logic [NUM_BANKS-1:0]        bank_req_o,
  output logic [ADDR_W-1:0]           bank_addr_o,
  input  logic [NUM_BANKS-1:0]        bank_ready_i,
  input  logic [NUM_BANKS-1:0]        bank_rsp_valid_i,
  input  logic [NUM_BANKS*DATA_W-1:0] bank_rsp_data_i,
  input  logic [NUM_BANKS-1:0]        bank_rsp_err_i
);
  localparam int BANK_W    = idx_width(NUM_BANKS);
  localparam int SEQ_DEPTH = OUTSTANDING * NUM_BANKS;

  logic [BANK_W-1:0]    sel, head;
  logic                 seq_empty, seq_full, accept;
  logic [NUM_BANKS-1:0] bank_free, due, out_valid, out_err;
  logic [DATA_W-1:0]    out_data [NUM_BANKS];

  assign sel         = req_addr_i[BANK_LSB +: BANK_W];
  assign req_ready_o = rst_ni & ~seq_full & bank_ready_i[sel] & bank_free[sel];
  assign accept      = req_valid_i & req_ready_o;
  assign bank_addr_o = req_addr_i;

  rspseq_order_fifo #(.DEPTH(SEQ_DEPTH), .W(BANK_W)) u_order (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (accept),
    .data_i  (sel),
    .pop_i   (rsp_done_o),
    .head_o  (head),
    .empty_o (seq_empty),
    .full_o  (seq_full)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_req_o[b] = accept & (sel == BANK_W'(b));
    assign due[b]        = ~seq_empty & (head == BANK_W'(b));

    rspseq_rsp_buf #(.DEPTH(OUTSTANDING), .DATA_W(DATA_W)) u_buf (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .issue_i     (bank_req_o[b]),
      .in_valid_i  (bank_rsp_valid_i[b]),
      .in_data_i   (bank_rsp_data_i[b*DATA_W +: DATA_W]),
      .in_err_i    (bank_rsp_err_i[b]),
      .due_i       (due[b]),
      .out_valid_o (out_valid[b]),
      .out_data_o  (out_data[b]),
      .out_err_o   (out_err[b]),
      .free_o      (bank_free[b])
    );
  end

  assign rsp_done_o = rst_ni & ~seq_empty & out_valid[head];
  assign rsp_data_o = out_data[head];
  assign rsp_err_o  = out_err[head];

  a_r1_accept_bank_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |-> bank_ready_i[sel]);
  a_r2_req_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_req_o));
  a_r7_passthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(due & bank_rsp_valid_i)) |-> rsp_done_o);
endmodule

// File: tb/resp_sequencer_tb.sv
module resp_sequencer_tb;
  localparam int NB = 4;
  localparam int DW = 16;
  localparam int AW = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, rsp_done, rsp_err;
  logic [DW-1:0] rsp_data;
  logic [NB-1:0] bank_req, bank_rdy, rsp_v, rsp_e;
  logic [AW-1:0] bank_addr;
  logic [NB*DW-1:0] rsp_d;

  int checks = 0, fails = 0, accepted = 0, delivered = 0;
  int lat [NB];
  int pend [NB];
  int cnt [NB];
  logic [AW-1:0] saddr [NB];
  logic [AW-1:0] exp_q [$];

  always #5 clk = ~clk;

  resp_sequencer #(.NUM_BANKS(NB), .DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .rsp_done_o(rsp_done), .rsp_data_o(rsp_data),
    .rsp_err_o(rsp_err), .bank_req_o(bank_req), .bank_addr_o(bank_addr),
    .bank_ready_i(bank_rdy), .bank_rsp_valid_i(rsp_v), .bank_rsp_data_i(rsp_d),
    .bank_rsp_err_i(rsp_e));

  function automatic logic [DW-1:0] fdata(input logic [AW-1:0] a);
    return DW'(a) * 16'd37 + 16'd5;
  endfunction
  function automatic logic ferr(input logic [AW-1:0] a);
    return (a % 5) == 3;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bank stubs: fixed latency per bank, one request at a time
  always @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      rsp_v[b] <= 1'b0;
      if (!rst_n) pend[b] <= 0;
      else begin
        if (pend[b] != 0) begin
          if (cnt[b] <= 1) begin
            rsp_v[b] <= 1'b1;
            rsp_d[b*DW +: DW] <= fdata(saddr[b]);
            rsp_e[b] <= ferr(saddr[b]);
            pend[b] <= 0;
          end else cnt[b] <= cnt[b] - 1;
        end
        if (bank_req[b]) begin
          pend[b] <= 1;
          cnt[b] <= lat[b];
          saddr[b] <= bank_addr;
        end
      end
    end
  end

  // request monitor: R2 and scoreboard push
  always @(posedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      chk(bank_req == NB'(1 << req_addr[1:0]) && bank_addr == req_addr,
          "R2 bank strobe", int'(bank_req), 1 << req_addr[1:0]);
      exp_q.push_back(req_addr);
      accepted++;
    end
  end

  // response monitor: R3 order/data, R4 error flag
  always @(negedge clk) begin
    if (rst_n && rsp_done) begin
      delivered++;
      if (exp_q.size() == 0) chk(0, "R10 extra response", 1, 0);
      else begin
        logic [AW-1:0] a;
        a = exp_q.pop_front();
        chk(rsp_data == fdata(a), "R3 order/data", int'(rsp_data), int'(fdata(a)));
        chk(rsp_err == ferr(a), "R4 error flag", int'(rsp_err), int'(ferr(a)));
      end
    end
  end

  task automatic send(input logic [AW-1:0] a);
    @(negedge clk);
    req_valid = 1; req_addr = a; #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    bank_rdy = '1;
    for (int b = 0; b < NB; b++) lat[b] = 1;
    // R9: reset state
    req_valid = 1; req_addr = 0;
    repeat (3) @(negedge clk);
    chk(req_ready == 0, "R9 ready in reset", req_ready, 0);
    chk(rsp_done == 0, "R9 done in reset", rsp_done, 0);
    rst_n = 1; req_valid = 0;
    @(negedge clk);
    req_valid = 1; #1;
    chk(req_ready == 1, "R1 ready after reset", req_ready, 1);
    req_valid = 0;

    // R7: pass-through in the cycle the bank answers
    send(8'd2);
    @(negedge clk);
    chk(rsp_done == 0, "R7 not early", rsp_done, 0);
    @(negedge clk);
    chk(rsp_done == 1, "R7 same-cycle pass-through", rsp_done, 1);
    drain();

    // R3/R5/R6: later bank finishes first, held until its turn
    lat[0] = 12; lat[1] = 1;
    send(8'd0); send(8'd1);
    repeat (3) @(negedge clk);
    req_valid = 1; req_addr = 8'd5; #1;
    chk(req_ready == 0, "R6 held bank blocked", req_ready, 0);
    chk(rsp_done == 0, "R5 early response held", rsp_done, 0);
    req_addr = 8'd6; #1;
    chk(req_ready == 1, "R1 other bank open", req_ready, 1);
    req_valid = 0;
    drain();

    // R1: bank not ready
    bank_rdy[3] = 0;
    @(negedge clk);
    req_valid = 1; req_addr = 8'd3; #1;
    chk(req_ready == 0, "R1 bank_ready low", req_ready, 0);
    req_valid = 0; bank_rdy[3] = 1;

    // R8: order FIFO full
    for (int b = 0; b < NB; b++) lat[b] = 20;
    for (int b = 0; b < NB; b++) send(AW'(b));
    for (int b = 0; b < NB; b++) begin
      @(negedge clk);
      req_valid = 1; req_addr = AW'(b + 4); #1;
      chk(req_ready == 0, "R8 full blocks", req_ready, 0);
    end
    req_valid = 0;
    drain();

    // sweep of latency patterns with streaming bursts
    for (int r = 0; r < 24; r++) begin
      for (int b = 0; b < NB; b++) lat[b] = ((b * (r % 5) + r) % 7) + 1;
      for (int i = 0; i < 16; i++) send(AW'(i * 13 + r * 5));
      drain();
    end

    chk(exp_q.size() == 0, "R10 all delivered", exp_q.size(), 0);
    chk(delivered == accepted, "R10 one per request", delivered, accepted);
    finish_run();
  end
endmodule